// File: doc/BRIEF.md
# Serial Port Modem Handshake and Loopback Unit

This block holds the handshake side of a 16550-style serial port. A control register drives four active-low handshake outputs and a loopback switch. A status register reports the present levels of the four handshake inputs and four sticky change flags. The change flags clear when software reads the status register. The OR of the change flags, gated by an enable from the interrupt enable logic, forms the modem-status interrupt request.

The external handshake inputs are asynchronous. They pass through a synchronizer chain before any change detection. In loopback mode the unit ignores the outside world. The transmit bit from the shifter is routed back to the receiver input. The serial output pin idles at the marking level. The handshake output pins sit at their inactive high level. The status inputs are fed from the low four control bits, with DTR feeding DSR, RTS feeding CTS, OUT1 feeding RI and OUT2 feeding DCD. The shift registers and the baud generator live elsewhere; this unit only steers the serial lines.

Top module: `modem_ctrl_loop`

## Requirements
- R1: After synchronous reset the control register is 0, all four handshake output pins are high, the status register reads 0x00 with the input pins high, the read data is 0 and the interrupt request is low.
- R2: A write at offset 4 stores bits 4..0. Bit 0 drives dtr_n, bit 1 drives rts_n, bit 2 drives out1_n and bit 3 drives out2_n, each pin being the complement of its bit. A read at offset 4 returns the stored bits with bits 7..5 reading 0.
- R3: A read at offset 6 returns the inverted, synchronized input levels in its upper nibble: bit 4 is CTS, bit 5 is DSR, bit 6 is RI and bit 7 is DCD.
- R4: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) are sticky change flags. Each sets when its active level changes in either direction.
- R5: Status bit 2 sets only when the active RI level falls, that is when ri_n goes from low to high. The opposite edge leaves it clear.
- R6: A read at offset 6 clears all four change flags. A change detected in the same cycle as that read is kept and shows on the following read.
- R7: With control bit 4 set, sout_pin is held at 1, rx_bit follows tx_bit and sin_pin has no effect. With it clear, sout_pin follows tx_bit and rx_bit follows sin_pin.
- R8: With control bit 4 set, all four handshake output pins are high whatever bits 3..0 hold. Changes on the four external input pins alter neither the status levels nor the change flags.
- R9: With control bit 4 set, the status levels come from the control bits: CTS from bit 1, DSR from bit 0, RI from bit 2 and DCD from bit 3. Changes of those bits set the change flags under the rules of R4 and R5.
- R10: irq_msi is high one cycle after msi_en is high while any change flag is set. It is low otherwise.
- R11: Writes at any offset other than 4 leave the control register unchanged. Reads at offsets other than 4 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| msi_en | input | 1 | Modem-status interrupt enable |
| irq_msi | output | 1 | Modem-status interrupt request |
| tx_bit | input | 1 | Serial bit from the transmit shifter |
| sout_pin | output | 1 | Serial output pin |
| sin_pin | input | 1 | Serial input pin |
| rx_bit | output | 1 | Serial bit to the receive shifter |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |

## Verification
The bench times a status read to land in the exact cycle a synchronized CTS change is detected. A design that clears before setting would lose that change, and the second read would show the flag clear. The ring flag is driven through both of its edges. A design that uses a plain toggle detector would flag the leading edge, and one with the polarity inverted would miss the trailing edge. In loopback the control bits are stepped one at a time so that every cross pairing is seen alone. A swapped pairing would put a level in the wrong status bit. The bench also toggles the external pins while loopback is active, and a design that leaks them would show changed levels or stray change flags.

// File: rtl/modem_pkg.sv
package modem_pkg;
  // Active-level view of the four handshake inputs; packed so that
  // bits 3..0 line up with status register bits 7..4.
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  localparam int FLAG_W   = 4;
  localparam int CTRL_W   = 5;
  localparam int LOOP_BIT = 4;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         stg[i] <= RST_VAL;
      else if (i == 0) stg[i] <= d;
      else             stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mdm_lines_t        cur,
  input  logic              rd_clr,
  output logic [FLAG_W-1:0] flags_q
);
  mdm_lines_t        prev_q;
  logic [FLAG_W-1:0] set_v;

  always_comb begin
    set_v[0] = cur.cts ^ prev_q.cts;
    set_v[1] = cur.dsr ^ prev_q.dsr;
    set_v[2] = prev_q.ri & ~cur.ri;      // trailing edge only
    set_v[3] = cur.dcd ^ prev_q.dcd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= cur;
      flags_q <= (rd_clr ? '0 : flags_q) | set_v;
    end
  end

  // R6
  rd_clear_keeps_new_chk: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> ((flags_q & ~$past(set_v)) == '0));

  // R5
  ring_trailing_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[2]) |-> $past(prev_q.ri && !cur.ri));

  // R4
  flags_hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr && set_v == '0) |=> $stable(flags_q));
endmodule

// File: rtl/mdm_line_mux.sv
module mdm_line_mux #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loop_en,
  input  logic [NPINS-1:0] ctl_bits,
  input  logic             tx_bit,
  input  logic             sin_pin,
  output logic             sout_pin,
  output logic             rx_bit,
  output logic [NPINS-1:0] pins_n_q
);
  always_ff @(posedge clk) begin
    if (rst)          pins_n_q <= '1;
    else if (loop_en) pins_n_q <= '1;
    else              pins_n_q <= ~ctl_bits;
  end

  assign sout_pin = loop_en ? 1'b1   : tx_bit;
  assign rx_bit   = loop_en ? tx_bit : sin_pin;

  // R8
  loop_pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_en && $past(loop_en)) |-> (pins_n_q == '1));
endmodule

// File: rtl/modem_ctrl_loop.sv
module modem_ctrl_loop
  import modem_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_OFS    = 4,
  parameter int STAT_OFS    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              msi_en,
  output logic              irq_msi,
  input  logic              tx_bit,
  output logic              sout_pin,
  input  logic              sin_pin,
  output logic              rx_bit,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);
  localparam int STAT_W = 2 * FLAG_W;

  logic              sel_ctrl, sel_stat, loop_en;
  logic [CTRL_W-1:0] ctrl_q;
  logic [FLAG_W-1:0] flags_q, sync_n, pins_n_q;
  mdm_lines_t        ext_lines, loop_lines, cur_lines;
  logic [STAT_W-1:0] stat_v;
  logic              unused_wdata_hi;

  assign sel_ctrl        = (bus_addr == ADDR_W'(CTRL_OFS));
  assign sel_stat        = (bus_addr == ADDR_W'(STAT_OFS));
  assign loop_en         = ctrl_q[LOOP_BIT];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst)                      ctrl_q <= '0;
    else if (bus_wr && sel_ctrl)  ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  mdm_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dcd_n, ri_n, dsr_n, cts_n}),
    .q   (sync_n)
  );

  always_comb begin
    ext_lines      = ~sync_n;
    loop_lines.cts = ctrl_q[1];
    loop_lines.dsr = ctrl_q[0];
    loop_lines.ri  = ctrl_q[2];
    loop_lines.dcd = ctrl_q[3];
    cur_lines      = loop_en ? loop_lines : ext_lines;
  end

  mdm_delta u_delta (
    .clk     (clk),
    .rst     (rst),
    .cur     (cur_lines),
    .rd_clr  (bus_rd && sel_stat),
    .flags_q (flags_q)
  );

  mdm_line_mux #(.NPINS(FLAG_W)) u_lines (
    .clk      (clk),
    .rst      (rst),
    .loop_en  (loop_en),
    .ctl_bits (ctrl_q[FLAG_W-1:0]),
    .tx_bit   (tx_bit),
    .sin_pin  (sin_pin),
    .sout_pin (sout_pin),
    .rx_bit   (rx_bit),
    .pins_n_q (pins_n_q)
  );

  assign {out2_n, out1_n, rts_n, dtr_n} = pins_n_q;
  assign stat_v = {cur_lines, flags_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_msi   <= 1'b0;
    end else begin
      irq_msi <= msi_en && (|flags_q);
      if (bus_rd) begin
        if (sel_ctrl)      bus_rdata <= DATA_W'(ctrl_q);
        else if (sel_stat) bus_rdata <= DATA_W'(stat_v);
        else               bus_rdata <= '0;
      end
    end
  end

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !msi_en |=> !irq_msi);

  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && sel_ctrl) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0));

  // R11
  ctrl_other_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !sel_ctrl) |=> (ctrl_q == $past(ctrl_q)));
endmodule

// File: tb/tb_modem_ctrl_loop.sv
module tb_modem_ctrl_loop;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic msi_en = 0, irq_msi;
  logic tx_bit = 1, sout_pin, sin_pin = 1, rx_bit;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic dtr_n, rts_n, out1_n, out2_n;
  int checks = 0, errors = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctrl_loop dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msi_en(msi_en), .irq_msi(irq_msi),
    .tx_bit(tx_bit), .sout_pin(sout_pin), .sin_pin(sin_pin), .rx_bit(rx_bit),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [3:0] opins();
    return {out2_n, out1_n, rts_n, dtr_n};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 irq", irq_msi, 1'b0);
    chk("R1 pins", opins(), 4'hF);
    rd(3'd4, d); chk("R1 ctrl", d, 8'h00);
    rd(3'd6, d); chk("R1 status", d, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(3'd4, 8'h0F); idle(2); chk("R2 pins all on", opins(), 4'h0);
    wr(3'd4, 8'h05); idle(2); chk("R2 pins 0x05", opins(), 4'b1010);
    wr(3'd4, 8'hE3); rd(3'd4, d); chk("R2 upper bits read 0", d, 8'h03);
    idle(1); chk("R2 pins 0x03", opins(), 4'b1100);
  endtask

  task automatic t_other();
    logic [7:0] d;
    wr(3'd5, 8'hFF); wr(3'd0, 8'h10);
    rd(3'd4, d); chk("R11 ctrl unchanged", d, 8'h03);
    rd(3'd5, d); chk("R11 other read zero", d, 8'h00);
    wr(3'd4, 8'h00); idle(2);
  endtask

  task automatic t_levels();
    logic [7:0] d;
    @(negedge clk); cts_n = 0; dcd_n = 0; idle(5);
    rd(3'd6, d); chk("R3/R4 cts dcd assert", d, 8'h99);
    rd(3'd6, d); chk("R6 cleared by read", d, 8'h90);
    @(negedge clk); cts_n = 1; dcd_n = 1; idle(5);
    rd(3'd6, d); chk("R4 release edge", d, 8'h09);
    @(negedge clk); dsr_n = 0; idle(5);
    rd(3'd6, d); chk("R3/R4 dsr", d, 8'h22);
    @(negedge clk); dsr_n = 1; idle(5);
    rd(3'd6, d); chk("R4 dsr release", d, 8'h02);
  endtask

  task automatic t_ring();
    logic [7:0] d;
    @(negedge clk); ri_n = 0; idle(5);
    rd(3'd6, d); chk("R5 leading edge no flag", d, 8'h40);
    @(negedge clk); ri_n = 1; idle(5);
    rd(3'd6, d); chk("R5 trailing edge flag", d, 8'h04);
    rd(3'd6, d); chk("R6 ring cleared", d, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    @(negedge clk); cts_n = 0;
    @(negedge clk); @(negedge clk);
    bus_addr = 3'd6; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
    chk("R6 coincident read misses flag", d[0], 1'b0);
    rd(3'd6, d); chk("R6 coincident change kept", d, 8'h11);
    @(negedge clk); cts_n = 1; idle(5);
    rd(3'd6, d);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    msi_en = 1;
    @(negedge clk); dsr_n = 0; idle(6);
    chk("R10 irq raised", irq_msi, 1'b1);
    rd(3'd6, d); idle(2);
    chk("R10 irq dropped after read", irq_msi, 1'b0);
    msi_en = 0;
    @(negedge clk); dsr_n = 1; idle(6);
    chk("R10 irq gated off", irq_msi, 1'b0);
    msi_en = 1; idle(2);
    chk("R10 irq on enable", irq_msi, 1'b1);
    rd(3'd6, d); msi_en = 0; idle(2);
  endtask

  task automatic t_serial();
    @(negedge clk); tx_bit = 0; sin_pin = 1; #1;
    chk("R7 normal sout", sout_pin, 1'b0);
    chk("R7 normal rx", rx_bit, 1'b1);
    wr(3'd4, 8'h10); sin_pin = 0; tx_bit = 1; #1;
    chk("R7 loop sout mark", sout_pin, 1'b1);
    chk("R7 loop rx=tx 1", rx_bit, 1'b1);
    @(negedge clk); tx_bit = 0; sin_pin = 1; #1;
    chk("R7 loop sout mark tx0", sout_pin, 1'b1);
    chk("R7 loop rx=tx 0", rx_bit, 1'b0);
    tx_bit = 1; sin_pin = 1;
  endtask

  task automatic t_loop_map();
    logic [7:0] d;
    idle(2); rd(3'd6, d); chk("R9 loop zero", d, 8'h00);
    wr(3'd4, 8'h11); idle(2); rd(3'd6, d); chk("R9 dtr->dsr", d, 8'h22);
    wr(3'd4, 8'h14); idle(2); rd(3'd6, d); chk("R9 out1->ri", d, 8'h42);
    wr(3'd4, 8'h10); idle(2); rd(3'd6, d); chk("R9 out1 fall trailing", d, 8'h04);
    wr(3'd4, 8'h18); idle(2); rd(3'd6, d); chk("R9 out2->dcd", d, 8'h88);
    wr(3'd4, 8'h12); idle(2); rd(3'd6, d); chk("R9 rts->cts", d, 8'h19);
    wr(3'd4, 8'h1F); idle(2); chk("R8 loop pins high", opins(), 4'hF);
    rd(3'd6, d);
  endtask

  task automatic t_isolation();
    logic [7:0] d;
    wr(3'd4, 8'h12); idle(2); rd(3'd6, d);
    @(negedge clk); cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0; idle(5);
    rd(3'd6, d); chk("R8 ext inputs ignored", d, 8'h10);
    @(negedge clk); ri_n = 1; cts_n = 1; idle(5);
    rd(3'd6, d); chk("R8 ext edges ignored", d, 8'h10);
    @(negedge clk); dsr_n = 1; dcd_n = 1;
    wr(3'd4, 8'h00); idle(5); rd(3'd6, d);
    rd(3'd6, d); chk("R3 back to external", d, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);
    t_reset();
    t_ctrl();
    t_other();
    t_levels();
    t_ring();
    t_race();
    t_irq();
    t_serial();
    t_loop_map();
    t_isolation();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule